// File: doc/BRIEF.md
# HDLC Receive Frame Processor

This block turns a serial line bit stream into HDLC packet bytes for a receive FIFO. A bit is taken on every clock where the bit strobe is high. The block looks for flags, removes the zeros that the transmitter inserted after runs of ones, and recognises aborts. It treats the final 16 bits before each closing flag as the frame check sequence and checks it with the reflected CRC-16-CCITT. Each address, control or information byte leaves the block on a one-clock pulse. Every byte carries a 2-bit code that marks it as first, middle, last of a good packet or last of a bad packet.

The frame check bits are never passed on as data. Instead, the bits that arrived in that slot are kept in a 16-bit register for software to read. A receive enable starts the receiver at once. Clearing it stops the receiver either right away or at the end of the current packet, depending on whether that packet has already put a byte out.

Top module: `hdlc_frame_rx`

## Requirements
- R1: After reset, `outValid` is low, `fcsCapture` is zero and the receiver stays idle until `rxEnable` is seen high.
- R2: A flag is the bit sequence 0,1,1,1,1,1,1,0 in arrival order. One flag may close a frame and open the next. Runs of back-to-back flags produce no output.
- R3: Inside a frame, a 0 that follows exactly five 1s is deleted, so a data byte of 0xFF or 0x7E is delivered intact.
- R4: Bytes are assembled least significant bit first, meaning the first received bit becomes bit 0. The last 16 bits before the closing flag are never output. `outValid` pulses only on the clock after a strobed bit, so a 32-bit frame yields exactly two bytes.
- R5: `outStatus` codes are 2'b01 for the first byte, 2'b00 for a byte inside the packet, 2'b10 for the last byte of a good packet and 2'b11 for the last byte of a bad packet. A middle byte only follows an open packet.
- R6: A packet is good only when the CRC residue over its content and FCS equals 0xF0B8, using polynomial 0x8408 reflected with a preset of 0xFFFF. Otherwise the last byte is tagged 2'b11.
- R7: A frame with fewer than 32 content bits, or with a bit count that is not a multiple of 8, is never tagged good. A frame with fewer than 24 content bits outputs nothing.
- R8: Seven consecutive 1s inside a frame abort it. Any byte still held back is output tagged 2'b11, and the receiver then waits for a flag.
- R9: Each closing flag of a frame with at least 16 content bits loads `fcsCapture` with the 16 bits found in the FCS position. The first bit received goes to bit 15, and the bits keep the values they had on the line.
- R10: Raising `rxEnable` activates the receiver on the next clock. A frame already under way when the receiver is enabled is ignored, because a full flag must be seen first.
- R11: Clearing `rxEnable` after a packet has output its first byte lets that packet finish normally. The receiver then stays idle.
- R12: Clearing `rxEnable` before the current packet has output any byte stops the receiver at once. The held bytes are discarded and nothing more is output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | Marks a clock carrying a valid line bit |
| rxBit | input | 1 | Serial line bit |
| rxEnable | input | 1 | Receiver enable |
| outValid | output | 1 | One-clock byte strobe toward the FIFO |
| outData | output | 8 | Received byte, first bit in bit 0 |
| outStatus | output | 2 | Byte status code (R5) |
| fcsCapture | output | 16 | Last captured FCS bits, first received in bit 15 |

## Verification
The hardest state to reach from the ports is an enable change that lands on either side of the first byte's release. That release happens 39 content bits into a frame, so the stimulus drops `rxEnable` at bit 10 of one frame and at bit 45 of another. A third frame is sent with the receiver off and is enabled at bit 5 of that frame. Frames carrying 0xFF and 0x7E bytes force zero deletion. Frames of 8, 24 and 35 content bits drive the length and alignment rules, and a run of seven ones is cut into a frame to force an abort.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  typedef enum logic [1:0] {
    RX_OFF   = 2'd0,
    RX_HUNT  = 2'd1,
    RX_FRAME = 2'd2
  } rxState_t;

  typedef enum logic [1:0] {
    TAG_MID   = 2'b00,
    TAG_FIRST = 2'b01,
    TAG_GOOD  = 2'b10,
    TAG_BAD   = 2'b11
  } byteTag_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic push;       // shift an unstuffed content bit in
    logic feedCrc;    // advance the CRC with the bit leaving the flag guard
    logic commit;     // a byte is known to be content
    logic closeGood;  // closing flag, packet good
    logic closeBad;   // closing flag or abort, packet bad
    logic capFcs;     // load the FCS register
    logic drop;       // discard held state and restart
  } rxStrobe_t;

endpackage

// File: rtl/hdlc_rx_ctrl.sv
module hdlc_rx_ctrl
  import hdlc_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FCS_W  = 16,
  parameter int CNT_W  = 12
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitEn,
  input  logic      rxBit,
  input  logic      rxEnable,
  input  logic      crcOk,
  output rxStrobe_t stb
);

  localparam int FLAG_ONES  = 6;
  localparam int STUFF_ONES = 5;
  localparam int ONES_W     = 3;
  localparam int FLAG_TAIL  = FLAG_ONES + 1;              // flag bits pushed before detection
  localparam int HOLD       = FCS_W + FLAG_TAIL;          // bits held back behind a byte
  localparam int WIN        = HOLD + DATA_W;              // count at which byte 0 is known
  localparam int MIN_CNT    = 2 * DATA_W + FCS_W + FLAG_TAIL;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  rxState_t            state, nextState;
  logic [ONES_W-1:0]   ones;
  logic [CNT_W-1:0]    bitCnt, nextCnt;
  logic                isFlag, isAbort, isStuff;
  logic                sentFirst, lenOk, commitNow;

  assign isFlag    = !rxBit && (ones == ONES_W'(FLAG_ONES));
  assign isAbort   =  rxBit && (ones == ONES_W'(FLAG_ONES));
  assign isStuff   = !rxBit && (ones == ONES_W'(STUFF_ONES));
  assign nextCnt   = (bitCnt == CNT_MAX) ? bitCnt : bitCnt + 1'b1;
  assign sentFirst = bitCnt >= CNT_W'(MIN_CNT);
  assign lenOk     = sentFirst &&
                     (((bitCnt - CNT_W'(FLAG_TAIL)) % CNT_W'(DATA_W)) == '0);
  assign commitNow = (nextCnt >= CNT_W'(WIN)) &&
                     (((nextCnt - CNT_W'(WIN)) % CNT_W'(DATA_W)) == '0);

  always_comb begin
    stb       = '0;
    nextState = state;
    unique case (state)
      RX_OFF: begin
        if (rxEnable) nextState = RX_HUNT;
      end
      RX_HUNT: begin
        if (!rxEnable) begin
          nextState = RX_OFF;
        end else if (bitEn && isFlag) begin
          nextState = RX_FRAME;
          stb.drop  = 1'b1;
        end
      end
      RX_FRAME: begin
        if (!rxEnable && !sentFirst) begin
          stb.drop  = 1'b1;
          nextState = RX_OFF;
        end else if (bitEn) begin
          if (isFlag) begin
            stb.closeGood = lenOk && crcOk;
            stb.closeBad  = !(lenOk && crcOk);
            stb.capFcs    = bitCnt >= CNT_W'(HOLD);
            nextState     = rxEnable ? RX_FRAME : RX_OFF;
          end else if (isAbort) begin
            stb.closeBad = 1'b1;
            nextState    = rxEnable ? RX_HUNT : RX_OFF;
          end else if (!isStuff) begin
            stb.push    = 1'b1;
            stb.feedCrc = nextCnt > CNT_W'(FLAG_TAIL);
            stb.commit  = commitNow;
          end
        end
      end
      default: nextState = RX_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= RX_OFF;
      ones   <= '1;
      bitCnt <= '0;
    end else begin
      state <= nextState;
      if (state == RX_OFF) begin
        ones <= '1;                       // run length unknown until a zero arrives
      end else if (bitEn) begin
        if (!rxBit)          ones <= '0;
        else if (ones != '1) ones <= ones + 1'b1;
      end
      if (stb.drop || stb.closeGood || stb.closeBad) bitCnt <= '0;
      else if (stb.push)                             bitCnt <= nextCnt;
    end
  end

endmodule

// File: rtl/hdlc_rx_dpath.sv
module hdlc_rx_dpath
  import hdlc_rx_pkg::*;
#(
  parameter int          DATA_W      = 8,
  parameter int          FCS_W       = 16,
  parameter logic [15:0] CRC_POLY    = 16'h8408,
  parameter logic [15:0] CRC_RESIDUE = 16'hF0B8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         stb,
  input  logic              rxBit,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [1:0]        outStatus,
  output logic [FCS_W-1:0]  fcsCapture,
  output logic              crcOk
);

  localparam int FLAG_TAIL = 7;
  localparam int HOLD      = FCS_W + FLAG_TAIL;
  localparam int WIN       = HOLD + DATA_W;

  logic [WIN-1:0]    hist, newHist;
  logic [FCS_W-1:0]  crc, crcNext;
  logic [DATA_W-1:0] pend, newByte;
  logic              pendValid, pendFirst;
  logic              crcFb;

  assign newHist = {hist[WIN-2:0], rxBit};
  // the bit that has just cleared the flag guard window
  assign crcFb   = crc[0] ^ hist[FLAG_TAIL-1];
  assign crcNext = (crc >> 1) ^ (crcFb ? CRC_POLY[FCS_W-1:0] : '0);
  assign crcOk   = crc == CRC_RESIDUE[FCS_W-1:0];

  always_comb begin
    for (int i = 0; i < DATA_W; i++) newByte[i] = newHist[WIN-1-i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hist       <= '0;
      crc        <= '1;
      pend       <= '0;
      pendValid  <= 1'b0;
      pendFirst  <= 1'b0;
      outValid   <= 1'b0;
      outData    <= '0;
      outStatus  <= TAG_MID;
      fcsCapture <= '0;
    end else begin
      outValid <= 1'b0;
      if (stb.push)    hist <= newHist;
      if (stb.feedCrc) crc  <= crcNext;
      if (stb.commit) begin
        if (pendValid) begin
          outValid  <= 1'b1;
          outData   <= pend;
          outStatus <= pendFirst ? TAG_FIRST : TAG_MID;
        end
        pend      <= newByte;
        pendFirst <= !pendValid;
        pendValid <= 1'b1;
      end
      if (stb.closeGood || stb.closeBad) begin
        if (pendValid) begin
          outValid  <= 1'b1;
          outData   <= pend;
          outStatus <= stb.closeGood ? TAG_GOOD : TAG_BAD;
        end
        pendValid <= 1'b0;
        crc       <= '1;
      end
      if (stb.capFcs) fcsCapture <= hist[HOLD-1:FLAG_TAIL];
      if (stb.drop) begin
        pendValid <= 1'b0;
        crc       <= '1;
      end
    end
  end

endmodule

// File: rtl/hdlc_frame_rx.sv
module hdlc_frame_rx
  import hdlc_rx_pkg::*;
#(
  parameter int          DATA_W      = 8,
  parameter int          FCS_W       = 16,
  parameter int          CNT_W       = 12,
  parameter logic [15:0] CRC_POLY    = 16'h8408,
  parameter logic [15:0] CRC_RESIDUE = 16'hF0B8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic              rxBit,
  input  logic              rxEnable,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [1:0]        outStatus,
  output logic [FCS_W-1:0]  fcsCapture
);

  rxStrobe_t stb;
  logic      crcOk;

  hdlc_rx_ctrl #(.DATA_W(DATA_W), .FCS_W(FCS_W), .CNT_W(CNT_W)) ctrl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .rxBit(rxBit),
    .rxEnable(rxEnable), .crcOk(crcOk), .stb(stb)
  );

  hdlc_rx_dpath #(.DATA_W(DATA_W), .FCS_W(FCS_W), .CRC_POLY(CRC_POLY),
                  .CRC_RESIDUE(CRC_RESIDUE)) dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .rxBit(rxBit),
    .outValid(outValid), .outData(outData), .outStatus(outStatus),
    .fcsCapture(fcsCapture), .crcOk(crcOk)
  );

endmodule

// File: rtl/hdlc_rx_chk.sv
module hdlc_rx_chk #(
  parameter int FCS_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             bitEn,
  input logic             rxEnable,
  input logic             outValid,
  input logic [1:0]       outStatus,
  input logic [FCS_W-1:0] fcsCapture
);

  logic inPkt, pktOpen;

  assign pktOpen = outValid ? (outStatus == 2'b01 || outStatus == 2'b00) : inPkt;

  always_ff @(posedge clk) begin
    if (!rstN) inPkt <= 1'b0;
    else       inPkt <= pktOpen;
  end

  // R5
  middle_in_pkt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outStatus == 2'b00) |-> inPkt);

  // R5
  first_outside_pkt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outStatus == 2'b01) |-> !inPkt);

  // R7
  good_needs_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outStatus == 2'b10) |-> inPkt);

  // R4
  byte_after_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> !outValid);

  // R9
  fcs_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> $stable(fcsCapture));

  // R12
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnable && !pktOpen) |=> !outValid);

endmodule

bind hdlc_frame_rx hdlc_rx_chk #(.FCS_W(FCS_W)) rxChk (
  .clk(clk), .rstN(rstN), .bitEn(bitEn), .rxEnable(rxEnable),
  .outValid(outValid), .outStatus(outStatus), .fcsCapture(fcsCapture)
);

// File: tb/hdlc_frame_rx_test.sv
`timescale 1ns/1ps
module hdlc_frame_rx_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitEn = 1'b0;
  logic        rxBit = 1'b1;
  logic        rxEnable = 1'b0;
  logic        outValid;
  logic [7:0]  outData;
  logic [1:0]  outStatus;
  logic [15:0] fcsCapture;

  always #2.5 clk = ~clk;

  hdlc_frame_rx uut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .rxBit(rxBit), .rxEnable(rxEnable),
    .outValid(outValid), .outData(outData), .outStatus(outStatus),
    .fcsCapture(fcsCapture)
  );

  int vecs = 0;
  int miss = 0;
  string curReq = "R1";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int   mMode = 0;            // 0 off, 1 waiting for flag, 2 in frame
  int   mOnes = 7;
  bit   bq[$];
  bit   expValid = 0;
  int   expData = 0, expStat = 0, expFcs = 0;

  function automatic bit crcGood(int n);
    int c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      if (((c & 1) ^ bq[i]) != 0) c = (c >> 1) ^ 16'h8408;
      else                        c = c >> 1;
    end
    return c == 16'hF0B8;
  endfunction

  function automatic void emitByte(int k, int st);
    int v = 0;
    for (int i = 0; i < 8; i++) if (bq[8*k+i]) v += (1 << i);
    expValid = 1;
    expData  = v;
    expStat  = st;
  endfunction

  function automatic void closeFrame(bit aborted);
    int n = bq.size();
    if (!aborted && n >= 23) begin
      expFcs = 0;
      for (int j = 0; j < 16; j++) if (bq[n-23+j]) expFcs += (1 << (15 - j));
    end
    if (n >= 31) begin
      bit good = !aborted && n >= 39 && ((n - 7) % 8 == 0) && crcGood(n - 7);
      emitByte((n - 31) / 8, good ? 2 : 3);
    end
    bq.delete();
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mOnes = 7; bq.delete();
      expValid = 0; expData = 0; expStat = 0; expFcs = 0;
    end else begin
      expValid = 0;
      case (mMode)
        0: if (rxEnable) begin mMode = 1; mOnes = 7; end
        1: begin
          if (!rxEnable) mMode = 0;
          else if (bitEn) begin
            if (!rxBit && mOnes == 6) begin mMode = 2; bq.delete(); end
            mOnes = rxBit ? ((mOnes < 7) ? mOnes + 1 : 7) : 0;
          end
        end
        default: begin
          if (!rxEnable && bq.size() < 39) begin
            mMode = 0; bq.delete();
          end else if (bitEn) begin
            if (!rxBit && mOnes == 6) begin
              closeFrame(0); mMode = rxEnable ? 2 : 0;
            end else if (rxBit && mOnes == 6) begin
              closeFrame(1); mMode = rxEnable ? 1 : 0;
            end else if (!(!rxBit && mOnes == 5)) begin
              int n;
              bq.push_back(rxBit);
              n = bq.size();
              if (n >= 39 && (n - 31) % 8 == 0) emitByte((n - 39) / 8, (n == 39) ? 1 : 0);
            end
            mOnes = rxBit ? ((mOnes < 7) ? mOnes + 1 : 7) : 0;
          end
        end
      endcase
    end
  end

  // per-clock comparison and port-side tallies
  int obsAny = 0, obsFirst = 0, obsGood = 0, obsBad = 0, firstData = -1;

  always @(negedge clk) begin
    if (rstN) begin
      chk(outValid == expValid, {curReq, " valid"}, outValid, expValid);
      if (outValid && expValid) begin
        chk(outData == expData[7:0], {curReq, " data"}, outData, expData);
        chk(outStatus == expStat[1:0], {curReq, " status"}, outStatus, expStat);
      end
      chk(fcsCapture == expFcs[15:0], {curReq, " fcs"}, fcsCapture, expFcs);
      if (outValid) begin
        obsAny++;
        if (outStatus == 2'b01) begin obsFirst++; if (firstData < 0) firstData = outData; end
        if (outStatus == 2'b10) obsGood++;
        if (outStatus == 2'b11) obsBad++;
      end
    end
  end

  task automatic phase(input string req);
    curReq = req;
    obsAny = 0; obsFirst = 0; obsGood = 0; obsBad = 0; firstData = -1;
  endtask

  // ---------------- stimulus ----------------
  logic [7:0] frm[$];
  bit         fb[$];
  logic [15:0] lastFcs;

  task automatic sendBit(input logic b);
    bitEn = 1'b1; rxBit = b;
    @(negedge clk);
    bitEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic sendFlag();
    sendBit(0);
    for (int i = 0; i < 6; i++) sendBit(1);
    sendBit(0);
  endtask

  task automatic sendFrame(input int extra, input bit corrupt, input int enIdx,
                           input bit enVal, input int abortAt);
    int c = 16'hFFFF;
    int run = 0;
    fb.delete();
    foreach (frm[i]) for (int j = 0; j < 8; j++) fb.push_back(frm[i][j]);
    for (int i = 0; i < extra; i++) fb.push_back(bit'(i % 2));
    foreach (fb[i]) begin
      if (((c & 1) ^ fb[i]) != 0) c = (c >> 1) ^ 16'h8408;
      else                        c = c >> 1;
    end
    for (int i = 0; i < 16; i++) begin
      fb.push_back(!c[i]);
      lastFcs[15-i] = !c[i];
    end
    if (corrupt) fb[fb.size()-1] = !fb[fb.size()-1];
    foreach (fb[i]) begin
      if (i == enIdx) rxEnable = enVal;
      if (i == abortAt) begin
        for (int k = 0; k < 7; k++) sendBit(1);
        return;
      end
      sendBit(fb[i]);
      run = fb[i] ? run + 1 : 0;
      if (run == 5) begin sendBit(0); run = 0; end
    end
    sendFlag();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miss++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(outValid == 1'b0, "R1 reset valid", outValid, 0);
    chk(fcsCapture == 16'h0, "R1 reset fcs", fcsCapture, 0);
    rstN = 1'b1;
    phase("R1");
    frm = {8'h12, 8'h34};
    sendFlag(); sendFrame(0, 0, -1, 0, -1);
    chk(obsAny == 0, "R1 idle while disabled", obsAny, 0);

    rxEnable = 1'b1;
    @(negedge clk);
    phase("R2");
    repeat (4) sendFlag();
    chk(obsAny == 0, "R2 back-to-back flags", obsAny, 0);

    phase("R4");
    frm = {8'hA5, 8'h3C};
    sendFrame(0, 0, -1, 0, -1);
    chk(obsAny == 2, "R4 min frame byte count", obsAny, 2);
    chk(obsFirst == 1 && obsGood == 1, "R5 first/good tags", obsGood, 1);
    chk(firstData == 8'hA5, "R4 bit order", firstData, 8'hA5);
    chk(fcsCapture == lastFcs, "R9 captured fcs", fcsCapture, lastFcs);

    phase("R2");
    frm = {8'h01, 8'h02, 8'h03};
    sendFrame(0, 0, -1, 0, -1);
    frm = {8'h04, 8'h05, 8'h06, 8'h07};
    sendFrame(0, 0, -1, 0, -1);
    chk(obsGood == 2, "R2 shared flag two packets", obsGood, 2);

    phase("R3");
    frm = {8'hFF, 8'h7E, 8'h3F, 8'hF8};
    sendFlag(); sendFrame(0, 0, -1, 0, -1);
    chk(firstData == 8'hFF, "R3 stuffed byte", firstData, 8'hFF);
    chk(obsGood == 1 && obsAny == 4, "R3 stuffed frame", obsAny, 4);

    phase("R6");
    frm = {8'h11, 8'h22, 8'h33};
    sendFrame(0, 1, -1, 0, -1);
    chk(obsBad == 1 && obsGood == 0, "R6 bad crc", obsBad, 1);

    phase("R7");
    frm = {8'h5A};
    sendFrame(0, 0, -1, 0, -1);
    chk(obsAny == 1 && obsBad == 1, "R7 24-bit frame", obsBad, 1);
    phase("R7");
    frm = {};
    sendFlag(); sendBit(0); sendBit(1); sendBit(0); sendBit(0);
    sendBit(1); sendBit(0); sendBit(1); sendBit(0); sendFlag();
    chk(obsAny == 0, "R7 tiny frame", obsAny, 0);
    phase("R7");
    frm = {8'h42, 8'h24};
    sendFrame(3, 0, -1, 0, -1);
    chk(obsGood == 0, "R7 misaligned never good", obsGood, 0);

    phase("R8");
    frm = {8'h10, 8'h20, 8'h30, 8'h40};
    sendFlag(); sendFrame(0, 0, -1, 0, 44);
    repeat (3) sendBit(1);
    chk(obsBad == 1 && obsGood == 0, "R8 abort", obsBad, 1);
    phase("R8");
    frm = {8'h55, 8'h66};
    sendFlag(); sendFrame(0, 0, -1, 0, -1);
    chk(obsGood == 1, "R8 recovery after flag", obsGood, 1);

    phase("R12");
    frm = {8'h12, 8'h34, 8'h56, 8'h78};
    sendFrame(0, 0, 10, 0, -1);
    sendFlag(); sendFrame(0, 0, -1, 0, -1);
    chk(obsAny == 0, "R12 early disable", obsAny, 0);

    phase("R10");
    frm = {8'h9A, 8'hBC, 8'hDE};
    sendFlag(); sendFrame(0, 0, 5, 1, -1);
    chk(obsAny == 0, "R10 mid-frame enable ignored", obsAny, 0);
    phase("R10");
    sendFrame(0, 0, -1, 0, -1);
    chk(obsGood == 1, "R10 next frame received", obsGood, 1);

    phase("R11");
    frm = {8'h12, 8'h34, 8'h56, 8'h78};
    sendFrame(0, 0, 45, 0, -1);
    chk(obsGood == 1 && obsAny == 4, "R11 late disable completes", obsAny, 4);
    phase("R11");
    sendFlag(); sendFrame(0, 0, -1, 0, -1);
    chk(obsAny == 0, "R11 idle after completion", obsAny, 0);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

endmodule